// File: doc/BRIEF.md
# Clock Mode Decoder and Ratio Divider

This block turns a set of quasi-static select pins into an operating mode for a system clock generator and produces the divided output clocks for that mode. In normal operation every divided clock is derived from one common high-rate synthesis clock (`src_clk`). In test mode the divided clocks come from an external clock driven on the crystal input (`xclk`), using fixed ratios. The block also returns an output-enable per clock group and a two-bit code that tells the spread modulator which spread profile to apply. The PLLs and the modulation itself sit outside.

Three selects pick the mode. `rate_sel` chooses the fast or the slow CPU rate. `lsel[1]` and `lsel[0]` choose between board-test high impedance, test mode, and normal modes. In the normal modes the 48 MHz domain is either enabled or parked in high impedance. The active-low `spread_n` pin requests spread modulation. The pins are synchronised inside the block. A new mode is adopted only at the end of a full period of the slowest divided clock, and all divider counters then restart together. As a result every divided clock rises on one common edge and no output ever carries a shortened pulse.

Top module: `ckm_clkgen`

## Requirements
- R1: With `rate_sel`=0 and `lsel`=00, `oe_core` and `oe_usb` are 0, every clock output including `ref_o` and `usb_o` stays low, and `spread_code` is 11. This is also the state held during reset.
- R2: With `rate_sel`=1 and `lsel[1]`=1, `cpu_o` has a period of 3 `src_clk` cycles and `cpuh_o` has a period of 6.
- R3: With `rate_sel`=0 and `lsel[1]`=1, `cpu_o` has a period of 4 `src_clk` cycles and `cpuh_o` has a period of 8.
- R4: In both normal rates, `m66_o`, `pci_o` and `lowf_o` have periods of 6, 12 and 24 `src_clk` cycles. The high phase of every divided clock lasts ceil(N/2) cycles of an N-cycle period. At the fast rate the `pci_o` period is four `cpu_o` periods.
- R5: With `lsel[1]`=1 and `lsel[0]`=0, `oe_usb` is 0 and `usb_o` stays low while `oe_core` is 1. With `lsel[0]`=1, `oe_usb` is 1 and `usb_o` follows `usb_src`.
- R6: Whenever `lowf_o` rises, every other divided clock rises in the same cycle.
- R7: `spread_code` is 00 when `spread_n`=1 in a normal mode. When `spread_n`=0 it is 01 for `lsel`=01 (center) and 10 for `lsel`=10 or 11 (down). It is 11 in high-impedance and test modes.
- R8: The reserved selects with `lsel`=01 run as a normal mode at the rate set by `rate_sel`, with the 48 MHz output enabled (default `RSV_AS_OFF`=0).
- R9: With `rate_sel`=1 and `lsel`=00 (test mode), the outputs are derived from `xclk`. The periods in `xclk` cycles are 2 for `cpu_o`, 4 for `cpuh_o`, 4 for `m66_o`, 8 for `pci_o`, 2 for `usb_o` and 16 for `lowf_o`. `spread_code` is 11 and `oe_usb` is 1.
- R10: A select change takes effect only when the current `lowf_o` period has completed. The period in which the change arrives keeps the old ratios in full, and the next period uses the new ratios.
- R11: While `oe_core` is 1, `ref_o` reproduces `xclk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Common high-rate synthesis clock |
| xclk | input | 1 | Crystal reference, or test clock in test mode |
| usb_src | input | 1 | 48 MHz domain clock for normal modes |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 1 | 1 = fast CPU rate, 0 = slow CPU rate |
| lsel | input | 2 | Logic selects (mode and spread type) |
| spread_n | input | 1 | Active-low spread request |
| cpu_o | output | 1 | CPU clock |
| cpuh_o | output | 1 | Half-rate CPU clock |
| m66_o | output | 1 | Fixed 66 MHz group clock |
| pci_o | output | 1 | PCI clock |
| lowf_o | output | 1 | Slowest divided clock (16.67 MHz) |
| usb_o | output | 1 | 48 MHz domain output |
| ref_o | output | 1 | Reference clock output |
| oe_core | output | 1 | Output enable for all groups except 48 MHz |
| oe_usb | output | 1 | Output enable for the 48 MHz output |
| spread_code | output | 2 | 00 none, 01 center, 10 down, 11 off/test |

## Verification
The bench builds the block with its default parameters: ratios 3/4, 6/8, 6, 12 and 24 from the synthesis clock, test ratios 2, 4, 4, 8, 2 and 16, two synchroniser stages, and reserved selects mapped to a running mode. With these values every divisor divides the slowest one. That lets the bench count exactly eight or six CPU pulses per slowest period across a rate change, and see all outputs rise together. The small ratios also keep measurements in both the synthesis and test clock domains to a few hundred cycles.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

   typedef enum logic [1:0] {
      MK_OFF  = 2'd0,
      MK_RUN  = 2'd1,
      MK_TEST = 2'd2
   } mkind_t;

   typedef enum logic [1:0] {
      SP_NONE   = 2'b00,
      SP_CENTER = 2'b01,
      SP_DOWN   = 2'b10,
      SP_NA     = 2'b11
   } spcode_t;

   typedef struct packed {
      mkind_t  kind;
      logic    fast;
      logic    usb_on;
      spcode_t sp;
   } mode_t;

   localparam int MODE_W = $bits(mode_t);

   localparam mode_t MODE_OFF = '{kind: MK_OFF, fast: 1'b0, usb_on: 1'b0, sp: SP_NA};

   // channel indices of the divider array
   localparam int NCH     = 6;
   localparam int CH_CPU  = 0;
   localparam int CH_HALF = 1;
   localparam int CH_M66  = 2;
   localparam int CH_PCI  = 3;
   localparam int CH_USB  = 4;
   localparam int CH_LOWF = 5;

   // select pins -> operating mode
   function automatic mode_t decode_sel(input logic f, input logic [1:0] ls,
                                        input logic spn, input logic rsv_off);
      mode_t m;
      m = MODE_OFF;
      case (ls)
         2'b00: begin
            if (f) begin
               m.kind   = MK_TEST;
               m.fast   = 1'b1;
               m.usb_on = 1'b1;
               m.sp     = SP_NA;
            end
         end
         2'b01: begin
            if (!rsv_off) begin
               m.kind   = MK_RUN;
               m.fast   = f;
               m.usb_on = 1'b1;
               m.sp     = spn ? SP_NONE : SP_CENTER;
            end
         end
         default: begin
            m.kind   = MK_RUN;
            m.fast   = f;
            m.usb_on = ls[0];
            m.sp     = spn ? SP_NONE : SP_DOWN;
         end
      endcase
      return m;
   endfunction

endpackage

// File: rtl/ckm_sync.sv
module ckm_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ckm_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stg[s] <= '0;
         end else begin
            stg[s] <= (s == 0) ? d : stg[(s == 0) ? 0 : s - 1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ckm_divch.sv
module ckm_divch #(
   parameter int DF = 3,
   parameter int DS = 4,
   parameter int DT = 2,
   parameter int CW = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic use_fast,
   input  logic use_test,
   output logic q,
   output logic last
);
   logic [CW-1:0] cnt;
   logic [CW-1:0] nxt;
   logic [CW-1:0] div_m1;
   logic [CW-1:0] hi_n;
   int            d;

   always_comb begin
      d      = use_test ? DT : (use_fast ? DF : DS);
      div_m1 = CW'(d - 1);
      hi_n   = CW'((d + 1) / 2);
      // an idle counter parks at all ones, so the first running edge wraps to 0
      last   = (cnt >= div_m1);
      nxt    = last ? '0 : cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '1;
         q   <= 1'b0;
      end else if (!run) begin
         cnt <= '1;
         q   <= 1'b0;
      end else begin
         cnt <= nxt;
         q   <= (nxt < hi_n);
      end
   end
endmodule

// File: rtl/ckm_ctrl.sv
module ckm_ctrl
   import ckm_pkg::*;
#(
   parameter bit RSV_AS_OFF = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       f_s,
   input  logic [1:0] ls_s,
   input  logic       spn_s,
   input  logic       bound,
   output mode_t      cur
);
   mode_t req;

   if (RSV_AS_OFF) begin : g_rsv_off
      always_comb req = decode_sel(f_s, ls_s, spn_s, 1'b1);
   end else begin : g_rsv_run
      always_comb req = decode_sel(f_s, ls_s, spn_s, 1'b0);
   end

   // adopt a new mode only where the slowest output period ends
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur <= MODE_OFF;
      end else if ((req != cur) && bound) begin
         cur <= req;
      end
   end
endmodule

// File: rtl/ckm_clkgen.sv
module ckm_clkgen
   import ckm_pkg::*;
#(
   parameter int CPU_DIV_FAST  = 3,
   parameter int CPU_DIV_SLOW  = 4,
   parameter int HALF_DIV_FAST = 6,
   parameter int HALF_DIV_SLOW = 8,
   parameter int M66_DIV       = 6,
   parameter int PCI_DIV       = 12,
   parameter int LOWF_DIV      = 24,
   parameter int T_CPU         = 2,
   parameter int T_HALF        = 4,
   parameter int T_M66         = 4,
   parameter int T_PCI         = 8,
   parameter int T_USB         = 2,
   parameter int T_LOWF        = 16,
   parameter int SYNC_STAGES   = 2,
   parameter bit RSV_AS_OFF    = 1'b0
) (
   input  logic       src_clk,
   input  logic       xclk,
   input  logic       usb_src,
   input  logic       rst_n,
   input  logic       rate_sel,
   input  logic [1:0] lsel,
   input  logic       spread_n,
   output logic       cpu_o,
   output logic       cpuh_o,
   output logic       m66_o,
   output logic       pci_o,
   output logic       lowf_o,
   output logic       usb_o,
   output logic       ref_o,
   output logic       oe_core,
   output logic       oe_usb,
   output logic [1:0] spread_code
);
   // the 48 MHz channel only runs from the test clock; its normal ratio is a placeholder
   localparam int USB_DIV_RUN = 2;
   localparam int DF [NCH] = '{CPU_DIV_FAST, HALF_DIV_FAST, M66_DIV, PCI_DIV, USB_DIV_RUN, LOWF_DIV};
   localparam int DS [NCH] = '{CPU_DIV_SLOW, HALF_DIV_SLOW, M66_DIV, PCI_DIV, USB_DIV_RUN, LOWF_DIV};
   localparam int DT [NCH] = '{T_CPU, T_HALF, T_M66, T_PCI, T_USB, T_LOWF};
   localparam int MAXD     = (LOWF_DIV > T_LOWF) ? LOWF_DIV : T_LOWF;
   localparam int CW       = $clog2(MAXD + 1);

   mode_t            cur;
   logic             dclk;
   logic             is_test;
   logic             run;
   logic [3:0]       pins_s;
   logic [NCH-1:0]   ch_q;
   logic [NCH-1:0]   ch_last;

   // divider clock: test clock in test mode, synthesis clock otherwise
   assign is_test = (cur.kind == MK_TEST);
   assign run     = (cur.kind != MK_OFF);
   assign dclk    = is_test ? xclk : src_clk;

   ckm_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (dclk),
      .rst_n (rst_n),
      .d     ({rate_sel, lsel, spread_n}),
      .q     (pins_s)
   );

   ckm_ctrl #(.RSV_AS_OFF(RSV_AS_OFF)) u_ctrl (
      .clk   (dclk),
      .rst_n (rst_n),
      .f_s   (pins_s[3]),
      .ls_s  (pins_s[2:1]),
      .spn_s (pins_s[0]),
      .bound (ch_last[CH_LOWF]),
      .cur   (cur)
   );

   for (genvar g = 0; g < NCH; g++) begin : g_ch
      if (DF[g] < 2 || DS[g] < 2 || DT[g] < 2) begin : g_bad_min
         $error("ckm_clkgen: every divisor must be at least 2");
      end
      if ((LOWF_DIV % DF[g]) != 0 || (LOWF_DIV % DS[g]) != 0 || (T_LOWF % DT[g]) != 0) begin : g_bad_align
         $error("ckm_clkgen: divisors must divide the slowest divisor");
      end
      ckm_divch #(.DF(DF[g]), .DS(DS[g]), .DT(DT[g]), .CW(CW)) u_div (
         .clk      (dclk),
         .rst_n    (rst_n),
         .run      (run),
         .use_fast (cur.fast),
         .use_test (is_test),
         .q        (ch_q[g]),
         .last     (ch_last[g])
      );
   end

   assign oe_core     = run;
   assign oe_usb      = run & cur.usb_on;
   assign spread_code = cur.sp;
   assign cpu_o       = oe_core & ch_q[CH_CPU];
   assign cpuh_o      = oe_core & ch_q[CH_HALF];
   assign m66_o       = oe_core & ch_q[CH_M66];
   assign pci_o       = oe_core & ch_q[CH_PCI];
   assign lowf_o      = oe_core & ch_q[CH_LOWF];
   assign usb_o       = oe_usb & (is_test ? ch_q[CH_USB] : usb_src);
   assign ref_o       = oe_core & xclk;
endmodule

// File: rtl/ckm_clkgen_chk.sv
module ckm_clkgen_chk (
   input logic       dclk,
   input logic       rst_n,
   input logic       oe_core,
   input logic       oe_usb,
   input logic       is_test,
   input logic [1:0] spread_code,
   input logic [5:0] mode_bits,
   input logic [5:0] ch_q,
   input logic [5:0] ch_last,
   input logic [6:0] outs
);
   // R1: nothing drives while the core group is disabled
   a_r1_off_quiet: assert property (@(posedge dclk) disable iff (!rst_n)
      !oe_core |-> (outs == 7'd0 && !oe_usb && spread_code == 2'b11));

   // R5: the 48 MHz enable never stands without the core enable
   a_r5_usb_under_core: assert property (@(posedge dclk) disable iff (!rst_n)
      oe_usb |-> oe_core);

   // R6: the slowest channel rises only together with all others
   a_r6_aligned_rise: assert property (@(posedge dclk) disable iff (!rst_n)
      $rose(ch_q[5]) |-> (&ch_q));

   // R6: all counters reach their wrap point together with the slowest one
   a_r6_aligned_wrap: assert property (@(posedge dclk) disable iff (!rst_n)
      (ch_last[5] && oe_core) |-> (&ch_last));

   // R9: test mode reports the off code and enables the 48 MHz output
   a_r9_test_flags: assert property (@(posedge dclk) disable iff (!rst_n)
      is_test |-> (spread_code == 2'b11 && oe_usb));

   // R10: the mode changes only after a completed slowest period
   a_r10_switch_on_bound: assert property (@(posedge dclk) disable iff (!rst_n)
      (mode_bits != $past(mode_bits)) |-> $past(ch_last[5]));
endmodule

bind ckm_clkgen ckm_clkgen_chk u_chk (
   .dclk        (dclk),
   .rst_n       (rst_n),
   .oe_core     (oe_core),
   .oe_usb      (oe_usb),
   .is_test     (is_test),
   .spread_code (spread_code),
   .mode_bits   (cur),
   .ch_q        (ch_q),
   .ch_last     (ch_last),
   .outs        ({cpu_o, cpuh_o, m66_o, pci_o, lowf_o, usb_o, ref_o})
);

// File: tb/tb_ckm_clkgen.sv
module tb_ckm_clkgen;
   logic       src_clk = 1'b0;
   logic       xclk    = 1'b0;
   logic       usb_src = 1'b0;
   logic       rst_n   = 1'b0;
   logic       rate_sel = 1'b0;
   logic [1:0] lsel     = 2'b00;
   logic       spread_n = 1'b1;
   logic       cpu_o, cpuh_o, m66_o, pci_o, lowf_o, usb_o, ref_o;
   logic       oe_core, oe_usb;
   logic [1:0] spread_code;

   int tests = 0;
   int fails = 0;
   bit done  = 0;

   always #10 src_clk = ~src_clk;   // 50 MHz
   always #17 xclk    = ~xclk;
   always #11 usb_src = ~usb_src;

   ckm_clkgen dut (
      .src_clk(src_clk), .xclk(xclk), .usb_src(usb_src), .rst_n(rst_n),
      .rate_sel(rate_sel), .lsel(lsel), .spread_n(spread_n),
      .cpu_o(cpu_o), .cpuh_o(cpuh_o), .m66_o(m66_o), .pci_o(pci_o),
      .lowf_o(lowf_o), .usb_o(usb_o), .ref_o(ref_o),
      .oe_core(oe_core), .oe_usb(oe_usb), .spread_code(spread_code)
   );

   wire [5:0] obs = {lowf_o, usb_o, pci_o, m66_o, cpuh_o, cpu_o};

   task automatic chk(input string req, input int act, input int exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input bit ut);
      if (ut) @(negedge xclk);
      else    @(negedge src_clk);
   endtask

   task automatic set_mode(input bit f, input logic [1:0] ls, input bit spn, input bit ut);
      rate_sel = f;
      lsel     = ls;
      spread_n = spn;
      repeat (100) @(negedge src_clk);
      if (ut) repeat (40) @(negedge xclk);
   endtask

   // period and high time of obs[idx], in samples of the chosen clock
   task automatic measure(input int idx, input bit ut, output int per, output int hi);
      bit prv;
      per = 0;
      hi  = 0;
      tick(ut);
      prv = obs[idx];
      for (int n = 0; n < 200; n++) begin
         tick(ut);
         if (!prv && obs[idx]) break;
         prv = obs[idx];
      end
      per = 1;
      hi  = 1;
      prv = 1'b1;
      for (int n = 0; n < 200; n++) begin
         tick(ut);
         if (!prv && obs[idx]) break;
         if (obs[idx]) hi++;
         per++;
         prv = obs[idx];
      end
   endtask

   task automatic sync_lowf_rise(input bit ut);
      bit prv;
      tick(ut);
      prv = lowf_o;
      for (int n = 0; n < 200; n++) begin
         tick(ut);
         if (!prv && lowf_o) break;
         prv = lowf_o;
      end
   endtask

   // from a lowf rise, count cpu rises up to and including the next lowf rise
   task automatic count_period(input bit ut, output int rises, output int per);
      bit pc, pl;
      pc = cpu_o;
      pl = lowf_o;
      rises = 0;
      per   = 0;
      for (int n = 0; n < 200; n++) begin
         tick(ut);
         per++;
         if (!pc && cpu_o) rises++;
         if (!pl && lowf_o) break;
         pc = cpu_o;
         pl = lowf_o;
      end
   endtask

   task automatic check_group(input string req, input int idx, input bit ut,
                              input int exp_per);
      int p, h;
      measure(idx, ut, p, h);
      chk({req, " period"}, p, exp_per);
      chk({req, " high"}, h, (exp_per + 1) / 2);
   endtask

   task automatic t_reset;
      chk("R1 reset oe_core", oe_core, 0);
      chk("R1 reset oe_usb", oe_usb, 0);
      chk("R1 reset code", spread_code, 3);
      chk("R1 reset outs", {obs, ref_o}, 0);
   endtask

   task automatic t_off;
      int hits = 0;
      set_mode(1'b0, 2'b00, 1'b1, 1'b0);
      chk("R1 off oe_core", oe_core, 0);
      chk("R1 off oe_usb", oe_usb, 0);
      chk("R1 off code", spread_code, 3);
      for (int n = 0; n < 60; n++) begin
         #7;
         if ({obs, ref_o} != 0) hits++;
      end
      chk("R1 off outputs low", hits, 0);
   endtask

   task automatic t_fast;
      int p, h, pc, pp, bad;
      set_mode(1'b1, 2'b11, 1'b1, 1'b0);
      check_group("R2 cpu fast", 0, 1'b0, 3);
      check_group("R2 half fast", 1, 1'b0, 6);
      check_group("R4 m66 fast", 2, 1'b0, 6);
      check_group("R4 pci fast", 3, 1'b0, 12);
      check_group("R4 lowf fast", 5, 1'b0, 24);
      measure(0, 1'b0, pc, h);
      measure(3, 1'b0, pp, h);
      chk("R4 pci is four cpu periods", pp, 4 * pc);
      chk("R7 code no spread", spread_code, 0);
      bad = 0;
      for (int k = 0; k < 3; k++) begin
         sync_lowf_rise(1'b0);
         if (obs[3:0] != 4'hF) bad++;
      end
      chk("R6 aligned rise", bad, 0);
   endtask

   task automatic t_slow;
      set_mode(1'b0, 2'b11, 1'b1, 1'b0);
      check_group("R3 cpu slow", 0, 1'b0, 4);
      check_group("R3 half slow", 1, 1'b0, 8);
      check_group("R4 m66 slow", 2, 1'b0, 6);
      check_group("R4 pci slow", 3, 1'b0, 12);
      check_group("R4 lowf slow", 5, 1'b0, 24);
   endtask

   task automatic t_usb;
      int bad = 0;
      set_mode(1'b1, 2'b10, 1'b1, 1'b0);
      chk("R5 usb parked oe_usb", oe_usb, 0);
      chk("R5 usb parked oe_core", oe_core, 1);
      for (int n = 0; n < 40; n++) begin
         #7;
         if (usb_o) bad++;
      end
      chk("R5 usb parked low", bad, 0);
      set_mode(1'b1, 2'b11, 1'b1, 1'b0);
      chk("R5 usb enabled", oe_usb, 1);
      bad = 0;
      for (int n = 0; n < 20; n++) begin
         @(usb_src);
         #2;
         if (usb_o != usb_src) bad++;
      end
      chk("R5 usb follows source", bad, 0);
   endtask

   task automatic t_ref;
      int bad = 0;
      for (int n = 0; n < 10; n++) begin
         @(posedge xclk); #2;
         if (!ref_o) bad++;
         @(negedge xclk); #2;
         if (ref_o) bad++;
      end
      chk("R11 ref follows xclk", bad, 0);
   endtask

   task automatic t_spread;
      set_mode(1'b1, 2'b01, 1'b0, 1'b0);
      chk("R7 center code", spread_code, 1);
      set_mode(1'b1, 2'b10, 1'b0, 1'b0);
      chk("R7 down code sel10", spread_code, 2);
      set_mode(1'b0, 2'b11, 1'b0, 1'b0);
      chk("R7 down code sel11", spread_code, 2);
      set_mode(1'b0, 2'b11, 1'b1, 1'b0);
      chk("R7 spread released", spread_code, 0);
   endtask

   task automatic t_reserved;
      set_mode(1'b0, 2'b01, 1'b1, 1'b0);
      chk("R8 reserved oe_core", oe_core, 1);
      chk("R8 reserved oe_usb", oe_usb, 1);
      check_group("R8 reserved cpu", 0, 1'b0, 4);
   endtask

   task automatic t_test;
      set_mode(1'b1, 2'b00, 1'b1, 1'b1);
      chk("R9 test code", spread_code, 3);
      chk("R9 test oe_usb", oe_usb, 1);
      check_group("R9 test cpu", 0, 1'b1, 2);
      check_group("R9 test half", 1, 1'b1, 4);
      check_group("R9 test m66", 2, 1'b1, 4);
      check_group("R9 test pci", 3, 1'b1, 8);
      check_group("R9 test usb", 4, 1'b1, 2);
      check_group("R9 test lowf", 5, 1'b1, 16);
      t_ref();
   endtask

   task automatic t_switch;
      int r, p;
      set_mode(1'b1, 2'b11, 1'b1, 1'b0);
      sync_lowf_rise(1'b0);
      rate_sel = 1'b0;
      count_period(1'b0, r, p);
      chk("R10 old period length", p, 24);
      chk("R10 old period cpu pulses", r, 8);
      count_period(1'b0, r, p);
      chk("R10 new period length", p, 24);
      chk("R10 new period cpu pulses", r, 6);
   endtask

   initial begin
      repeat (5) @(negedge src_clk);
      t_reset();
      rst_n = 1'b1;
      t_off();
      t_fast();
      t_ref();
      t_slow();
      t_usb();
      t_spread();
      t_reserved();
      t_test();
      t_switch();
      t_off();
      if (!done) begin
         done = 1;
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         done = 1;
         tests++;
         fails++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule